// File: doc/BRIEF.md
# Double-Width Sequential Integer Divider

This unit divides a double-width dividend by a single-width divisor, where the operand width n is chosen per operation from 8, 16, 32 or 64 bits. The dividend arrives split over two 64-bit inputs: an accumulator value (low half) and a data value (high half). The one exception is the 8-bit width, where the whole 16-bit dividend sits in the low 16 bits of the accumulator. The division is unsigned or two's-complement signed. Results are an n-bit quotient and an n-bit remainder, written into the accumulator and data result registers.

An operation starts with a one-cycle `start` while the unit is idle. A restoring shift-subtract loop then produces one quotient bit per cycle, and `done` pulses when the operation is over. A zero divisor, or a quotient that does not fit in n bits, raises `fault` together with `done`. In that case neither result register is written. A separate combinational output gives the high half that sign-extends the low accumulator half. Software uses it to prepare the dividend before a signed divide. To divide one 8-bit unsigned value by another, clear the upper accumulator byte first.

Top module: `div_unit`

## Requirements
- R1: After reset, `busy`, `done` and `fault` are 0, and `accOut` and `dataOut` are 0.
- R2: A `start` seen while idle makes `busy` high for exactly 2n+1 cycles, with n = 8 << `sizeSel` (`sizeSel` 0,1,2,3 selects 8,16,32,64). `start` has no effect while `busy` is high, and inputs changed during the run do not alter the result.
- R3: `done` is high for exactly one cycle, the first cycle after `busy` falls. `fault` is high only in a cycle where `done` is high.
- R4: For n = 8, the dividend is `accIn[15:0]`. On success, `accOut` becomes {48'b0, remainder[7:0], quotient[7:0]} and `dataOut` is left unchanged.
- R5: For n = 16, 32 and 64, the dividend is {`dataIn[n-1:0]`, `accIn[n-1:0]`}. On success, `accOut` is the quotient and `dataOut` is the remainder, each zero-extended to 64 bits.
- R6: With `signedOp` = 0, both operands are unsigned, quotient = floor(dividend / divisor) and remainder = dividend mod divisor.
- R7: If the low n bits of `divisor` are all zero, the operation faults. Divisor bits above n are ignored.
- R8: In unsigned mode, a quotient of 2^n or more faults (for example, 16'h8000 / 2 at n = 8).
- R9: With `signedOp` = 1, both operands are two's complement. The quotient truncates toward zero and a nonzero remainder takes the sign of the dividend.
- R10: In signed mode, a quotient outside -2^(n-1) to 2^(n-1)-1 faults. This includes the most negative dividend divided by -1.
- R11: On a fault, `accOut` and `dataOut` keep their previous values.
- R12: `extHigh` equals n copies of `accIn[n-1]`, zero-extended to 64 bits. It is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (used only while idle) |
| sizeSel | input | 2 | Operand width select: 0=8, 1=16, 2=32, 3=64 |
| signedOp | input | 1 | 1 = signed division, 0 = unsigned |
| accIn | input | 64 | Low dividend half (whole dividend for n=8) |
| dataIn | input | 64 | High dividend half for n >= 16 |
| divisor | input | 64 | Divisor, low n bits used |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Divide fault, coincident with done |
| accOut | output | 64 | Accumulator result register |
| dataOut | output | 64 | Data result register |
| extHigh | output | 64 | Sign extension of the low accumulator half |

## Verification
The completion pulse and the fault decision fall in the same cycle. In that cycle the unit must either write both result registers or write neither. The bench provokes this with zero divisors, unsigned quotient overflow and the signed most-negative-by-minus-one case, each placed between successful divides that leave known values in the result registers. After each such fault it checks that `fault` coincides with `done` and that both outputs still hold the values of the previous successful operation. A second collision, a new `start` arriving while the loop is running, is provoked with changed operands. The bench judges it by the unchanged busy length and by results that belong to the first request.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {SZ8 = 2'd0, SZ16 = 2'd1, SZ32 = 2'd2, SZ64 = 2'd3} divSize_e;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } divCtrl_t;
endpackage

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int MAX_W = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] sizeSel,
  output logic       busy,
  output divCtrl_t   ctrl
);
  localparam int CNT_W = $clog2(2 * MAX_W);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} state_e;

  state_e           state;
  logic [CNT_W-1:0] stepCnt;
  divSize_e         sizeR;
  logic [CNT_W-1:0] lastStep;

  assign lastStep = CNT_W'((16 << sizeR) - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      sizeR   <= SZ8;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_RUN;
          stepCnt <= '0;
          sizeR   <= divSize_e'(sizeSel);
        end
        ST_RUN: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == lastStep) state <= ST_FIN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl.load   = (state == ST_IDLE) && start;
    ctrl.step   = (state == ST_RUN);
    ctrl.finish = (state == ST_FIN);
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/div_datapath.sv
module div_datapath
  import div_pkg::*;
#(
  parameter int MAX_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  divCtrl_t         ctrl,
  input  logic [1:0]       sizeSel,
  input  logic             signedOp,
  input  logic [MAX_W-1:0] accIn,
  input  logic [MAX_W-1:0] dataIn,
  input  logic [MAX_W-1:0] divisor,
  output logic             done,
  output logic             fault,
  output logic [MAX_W-1:0] accOut,
  output logic [MAX_W-1:0] dataOut
);
  localparam int DW = 2 * MAX_W;
  localparam int RW = MAX_W + 1;

  divSize_e         sizeR;
  logic             signedR, qNegR, rNegR, zeroR;
  logic [RW-1:0]    remR;
  logic [DW-1:0]    quoR;
  logic [MAX_W-1:0] divR;

  // operand preparation at load
  int unsigned      nIn;
  logic [MAX_W-1:0] maskIn, dvN, vMag;
  logic [DW-1:0]    maskDw, dividend, dMag;
  logic             dSign, vSign;

  always_comb begin
    nIn      = 8 << sizeSel;
    maskIn   = {MAX_W{1'b1}} >> (MAX_W - nIn);
    maskDw   = {DW{1'b1}} >> (DW - 2 * nIn);
    if (divSize_e'(sizeSel) == SZ8) dividend = DW'(accIn[15:0]);
    else dividend = (DW'(dataIn & maskIn) << nIn) | DW'(accIn & maskIn);
    dvN      = divisor & maskIn;
    dSign    = dividend[2*nIn-1];
    vSign    = dvN[nIn-1];
    dMag     = (signedOp && dSign) ? ((-dividend) & maskDw) : dividend;
    vMag     = (signedOp && vSign) ? ((-dvN) & maskIn) : dvN;
  end

  // one restoring step
  logic [RW-1:0] shifted, trial;
  logic          fits;
  always_comb begin
    shifted = {remR[RW-2:0], quoR[DW-1]};
    fits    = shifted >= {1'b0, divR};
    trial   = shifted - {1'b0, divR};
  end

  // completion: range check and sign restore
  int unsigned      nR;
  logic [MAX_W-1:0] maskR, qRes, rRes, rMag;
  logic [DW-1:0]    lim, qSgn;
  logic             overflow, flt;
  always_comb begin
    nR    = 8 << sizeR;
    maskR = {MAX_W{1'b1}} >> (MAX_W - nR);
    lim   = DW'(1) << (nR - 1);
    if (!signedR)   overflow = (quoR >> nR) != '0;
    else if (qNegR) overflow = quoR > lim;
    else            overflow = quoR > (lim - DW'(1));
    flt   = zeroR || overflow;
    qSgn  = qNegR ? -quoR : quoR;
    qRes  = qSgn[MAX_W-1:0] & maskR;
    rMag  = remR[MAX_W-1:0];
    rRes  = (rNegR ? -rMag : rMag) & maskR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sizeR <= SZ8; signedR <= 1'b0; qNegR <= 1'b0; rNegR <= 1'b0; zeroR <= 1'b0;
      remR <= '0; quoR <= '0; divR <= '0;
      done <= 1'b0; fault <= 1'b0; accOut <= '0; dataOut <= '0;
    end else begin
      done  <= ctrl.finish;
      fault <= ctrl.finish && flt;
      if (ctrl.load) begin
        sizeR   <= divSize_e'(sizeSel);
        signedR <= signedOp;
        qNegR   <= signedOp && (dSign ^ vSign);
        rNegR   <= signedOp && dSign;
        zeroR   <= (dvN == '0);
        remR    <= '0;
        quoR    <= dMag << (DW - 2 * nIn);
        divR    <= vMag;
      end
      if (ctrl.step) begin
        remR <= fits ? trial : shifted;
        quoR <= {quoR[DW-2:0], fits};
      end
      if (ctrl.finish && !flt) begin
        if (sizeR == SZ8) accOut <= MAX_W'({rRes[7:0], qRes[7:0]});
        else begin
          accOut  <= qRes;
          dataOut <= rRes;
        end
      end
    end
  end
endmodule

// File: rtl/div_unit.sv
module div_unit
  import div_pkg::*;
#(
  parameter int MAX_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       sizeSel,
  input  logic             signedOp,
  input  logic [MAX_W-1:0] accIn,
  input  logic [MAX_W-1:0] dataIn,
  input  logic [MAX_W-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic             fault,
  output logic [MAX_W-1:0] accOut,
  output logic [MAX_W-1:0] dataOut,
  output logic [MAX_W-1:0] extHigh
);
  divCtrl_t ctrl;

  div_ctrl #(.MAX_W(MAX_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .sizeSel(sizeSel),
    .busy(busy), .ctrl(ctrl)
  );

  div_datapath #(.MAX_W(MAX_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .sizeSel(sizeSel), .signedOp(signedOp),
    .accIn(accIn), .dataIn(dataIn), .divisor(divisor),
    .done(done), .fault(fault), .accOut(accOut), .dataOut(dataOut)
  );

  // sign-extension helper (R12)
  int unsigned extN;
  always_comb begin
    extN    = 8 << sizeSel;
    extHigh = accIn[extN-1] ? ({MAX_W{1'b1}} >> (MAX_W - extN)) : '0;
  end
endmodule

// File: rtl/div_unit_chk.sv
module div_unit_chk #(
  parameter int MAX_W = 64
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [1:0]       sizeSel,
  input logic             busy,
  input logic             done,
  input logic             fault,
  input logic [MAX_W-1:0] accOut,
  input logic [MAX_W-1:0] dataOut
);
  localparam int LW = $clog2(2 * MAX_W + 2) + 1;

  logic [LW-1:0] busyLen, expLen;
  logic [1:0]    sizeLatch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyLen   <= '0;
      sizeLatch <= '0;
    end else begin
      busyLen <= busy ? busyLen + 1'b1 : '0;
      if (!busy && start) sizeLatch <= sizeSel;
    end
  end
  assign expLen = LW'((16 << sizeLatch) + 1);

  a_r2_busy_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyLen == expLen));
  a_r2_no_done_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done);
  a_r3_done_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r3_fault_with_done: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> done);
  a_r11_fault_hold: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> ($stable(accOut) && $stable(dataOut)));
endmodule

bind div_unit div_unit_chk #(.MAX_W(MAX_W)) i_chk (.*);

// File: tb/test_div_unit.sv
`timescale 1ns/1ps
module test_div_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  sizeSel = '0;
  logic        signedOp = 1'b0;
  logic [63:0] accIn = '0, dataIn = '0, divisor = '0;
  logic        busy, done, fault;
  logic [63:0] accOut, dataOut, extHigh;

  int total = 0;
  int failed = 0;
  bit finished = 0;
  logic [63:0] expAcc = '0, expData = '0;

  always #2.5 clk = ~clk;

  div_unit i_div_unit (
    .clk(clk), .rstN(rstN), .start(start), .sizeSel(sizeSel), .signedOp(signedOp),
    .accIn(accIn), .dataIn(dataIn), .divisor(divisor),
    .busy(busy), .done(done), .fault(fault),
    .accOut(accOut), .dataOut(dataOut), .extHigh(extHigh)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // behavioural reference using the language's own division operators
  task automatic refDiv(input int sz, input bit sgn, input logic [63:0] a, input logic [63:0] d,
                        input logic [63:0] v, output bit flt, output logic [63:0] q, output logic [63:0] r);
    int n;
    logic [127:0] m, u, dv, qu, ru;
    logic signed [127:0] sd, sv, qs, rs, lim;
    n  = 8 << sz;
    m  = (128'd1 << n) - 1;
    u  = (sz == 0) ? {112'd0, a[15:0]} : ((({64'd0, d}) & m) << n) | ({64'd0, a} & m);
    dv = {64'd0, v} & m;
    flt = (dv == 0);
    q = '0; r = '0;
    if (!flt) begin
      if (!sgn) begin
        qu = u / dv; ru = u % dv;
        flt = (qu > m);
        q = qu[63:0]; r = ru[63:0];
      end else begin
        sd = u << (128 - 2 * n);  sd = sd >>> (128 - 2 * n);
        sv = dv << (128 - n);     sv = sv >>> (128 - n);
        qs = sd / sv; rs = sd % sv;
        lim = 128'sd1 <<< (n - 1);
        flt = (qs > lim - 128'sd1) || (qs < -lim);
        q = qs[63:0] & m[63:0]; r = rs[63:0] & m[63:0];
      end
    end
  endtask

  task automatic runOp(input string req, input int sz, input bit sgn, input logic [63:0] a,
                       input logic [63:0] d, input logic [63:0] v, input bit expFlt, input bit poke);
    bit flt, busyOk;
    logic [63:0] q, r;
    int n;
    n = 8 << sz;
    refDiv(sz, sgn, a, d, v, flt, q, r);
    chk({req, " model fault class"}, {63'd0, flt}, {63'd0, expFlt});
    @(negedge clk);
    sizeSel = sz[1:0]; signedOp = sgn; accIn = a; dataIn = d; divisor = v; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busyOk = 1;
    for (int k = 1; k <= 2 * n + 1; k++) begin
      if (!(busy === 1'b1 && done === 1'b0)) busyOk = 0;
      if (poke && k == 3) begin
        start = 1'b1; accIn = ~a; dataIn = ~d; divisor = v + 64'd3; signedOp = ~sgn;
      end
      if (poke && k == 6) start = 1'b0;
      @(negedge clk);
    end
    chk({req, " R2 busy held 2n+1"}, {63'd0, busyOk}, 64'd1);
    chk({req, " R2 busy low after"}, {63'd0, busy}, 64'd0);
    chk({req, " R3 done pulse"}, {63'd0, done}, 64'd1);
    chk({req, " R3/R7/R8/R10 fault"}, {63'd0, fault}, {63'd0, flt});
    if (!flt) begin
      if (sz == 0) expAcc = {48'd0, r[7:0], q[7:0]};
      else begin expAcc = q; expData = r; end
    end
    chk({req, " accOut (R4/R5/R11)"}, accOut, expAcc);
    chk({req, " dataOut (R4/R5/R11)"}, dataOut, expData);
    @(negedge clk);
    chk({req, " R3 done single cycle"}, {63'd0, done}, 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; failed++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", {63'd0, busy}, 64'd0);
    chk("R1 done", {63'd0, done}, 64'd0);
    chk("R1 fault", {63'd0, fault}, 64'd0);
    chk("R1 accOut", accOut, 64'd0);
    chk("R1 dataOut", dataOut, 64'd0);
    rstN = 1'b1;

    // R12 helper
    @(negedge clk);
    sizeSel = 2'd0; accIn = 64'h0000_0000_0000_0080; #1;
    chk("R12 ext 8 neg", extHigh, 64'hFF);
    sizeSel = 2'd2; accIn = 64'h0000_0000_7FFF_FFFF; #1;
    chk("R12 ext 32 pos", extHigh, 64'd0);
    sizeSel = 2'd3; accIn = 64'h8000_0000_0000_0000; #1;
    chk("R12 ext 64 neg", extHigh, 64'hFFFF_FFFF_FFFF_FFFF);
    sizeSel = 2'd1; accIn = 64'h0000_0000_0000_8000; #1;
    chk("R12 ext 16 neg", extHigh, 64'h0000_0000_0000_FFFF);

    // R4 / R6: 8-bit unsigned, dataIn junk must be ignored
    runOp("R4 R6 u8 100/7", 0, 0, 64'h0000_0000_0000_0064, 64'hDEAD, 64'h7, 0, 0);
    // R8: 0x8000/2 at 8 bits overflows, R11 hold
    runOp("R8 R11 u8 8000/2", 0, 0, 64'h8000, 64'h0, 64'h2, 1, 0);
    // R7: only low byte of divisor counts
    runOp("R7 u8 div zero", 0, 0, 64'h0040, 64'h0, 64'h100, 1, 0);
    // R5 / R6 wider unsigned
    runOp("R5 R6 u16", 1, 0, 64'h0000, 64'h0001, 64'h0010, 0, 0);
    runOp("R5 R6 u32", 2, 0, 64'h0000_0000_89AB_CDEF, 64'h0000_0000_0123_4567, 64'h0000_0000_F00D_0001, 0, 0);
    runOp("R5 R6 u64", 3, 0, 64'hFEDC_BA98_7654_3210, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFF1, 0, 0);
    runOp("R8 u16 overflow", 1, 0, 64'h0000, 64'h0010, 64'h0010, 1, 0);
    // R9 signed
    runOp("R9 s8 -100/7", 0, 1, 64'hFF9C, 64'h0, 64'h07, 0, 0);
    runOp("R9 s16 -7/2", 1, 1, 64'hFFF9, 64'hFFFF, 64'h0002, 0, 0);
    runOp("R9 s16 7/-2", 1, 1, 64'h0007, 64'h0000, 64'hFFFE, 0, 0);
    runOp("R9 s64", 3, 1, 64'h8765_4321_0FED_CBA9, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_1234, 0, 0);
    // R10 boundaries
    runOp("R10 s8 -128/1", 0, 1, 64'hFF80, 64'h0, 64'h01, 0, 0);
    runOp("R10 s8 -128/-1", 0, 1, 64'hFF80, 64'h0, 64'hFF, 1, 0);
    runOp("R10 s32 min/-1", 2, 1, 64'h8000_0000, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 1, 0);
    runOp("R7 s32 div zero", 2, 1, 64'h1234, 64'h0, 64'hFFFF_FFFF_0000_0000, 1, 0);
    runOp("R10 s16 +range", 1, 1, 64'hFFFF, 64'h3FFF, 64'h0002, 1, 0);
    // R2: start during run has no effect
    runOp("R2 start ignored", 2, 0, 64'h0000_0000_0000_03E8, 64'h0, 64'h0000_0000_0000_0009, 0, 1);

    finished = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule